// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of virtual-page-to-frame translations. Every slot carries the identifier of the process that owns it. A requester presents a virtual page number, its process identifier and whether the access is a write. All slots are compared at once. One cycle later the block returns exactly one of three outcomes:

- a hit, which carries the physical frame;
- a permission fault;
- a miss, which tells the requester to walk the page tables itself.

A slot can map a plain 4 KB page or a larger 2 MB or 1 GB region. For the larger regions, the low page-number bits take no part in the compare and are copied into the returned frame.

Entries are loaded through a fill port. A new entry goes to the lowest free slot; when every slot is full it goes to the slot named by a rotating victim pointer. A purge port removes any entry that covers a given page for a given process, which keeps stale translations out after a permission change. A flush input empties the whole buffer, for example on a context switch.

Top module: `tlb_pid_cam`

## Requirements
- R1: After reset every slot is empty and all result outputs are 0. A lookup made straight after reset reports a miss.
- R2: A lookup presented in cycle t produces its result after clock edge t with `resValid`=1. Exactly one of `resHit`, `resMiss` and `resFault` is then 1. With no lookup, all result outputs are 0.
- R3: A lookup hits only a slot that holds a valid entry, that carries a process identifier equal to `lkPid`, and whose page number matches `lkVpn` on the compared bits. In every other case the result is a miss with `resPfn`=0.
- R4: A read that matches a slot, or a write that matches a slot with `insWritable`=1, returns a hit with the stored frame. A write that matches a read-only slot returns `resFault`=1 with `resPfn`=0.
- R5: Size code 0 is a 4 KB page, 1 is a 2 MB region and 2 is a 1 GB region; code 3 behaves as 4 KB. For code 1, bits [8:0] of the page number are left out of the compare. For code 2, bits [17:0] are left out. The bits left out replace the same low bits of the returned frame.
- R6: A fill goes to the lowest-numbered empty slot whenever one exists. The victim pointer does not move on such a fill.
- R7: A fill into a full buffer replaces the slot named by the victim pointer. The pointer starts at 0 after reset and then advances by one, wrapping after the last slot.
- R8: A purge empties every valid slot whose process identifier equals `purgePid` and whose region covers `purgeVpn`. All other slots stay as they were.
- R9: `flushAll` empties every slot in one cycle.
- R10: A fill requested in the same cycle as a purge or a flush is dropped.
- R11: A lookup made in the same cycle as a fill, purge or flush sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkVpn | input | VPN_W | Virtual page number to translate |
| lkPid | input | PID_W | Process identifier of the requester |
| lkWrite | input | 1 | 1 = write access, 0 = read |
| resValid | output | 1 | Result present (one cycle after the request) |
| resHit | output | 1 | Translation found and permitted |
| resMiss | output | 1 | No matching entry; walk the page tables |
| resFault | output | 1 | Write to a read-only entry |
| resPfn | output | PFN_W | Physical frame, region offset bits merged in |
| insValid | input | 1 | Fill request |
| insVpn | input | VPN_W | Page number of the new entry |
| insPid | input | PID_W | Owning process of the new entry |
| insPfn | input | PFN_W | Frame of the new entry |
| insWritable | input | 1 | 1 = read/write, 0 = read-only |
| insSize | input | 2 | Region size code (0: 4 KB, 1: 2 MB, 2: 1 GB) |
| purgeValid | input | 1 | Purge request |
| purgeVpn | input | VPN_W | Page whose covering entries are removed |
| purgePid | input | PID_W | Process whose entries are removed |
| flushAll | input | 1 | Empty every slot |

## Verification
The bench targets several corner cases, each with a matching wrong behaviour:

- **Foreign process:** a lookup for the right page but from another process must miss; a design that ignores the process tag returns a hit.
- **Write to read-only:** a write to a read-only entry must fault; a design that skips the permission check hands out a frame.
- **Region offsets:** lookups inside 2 MB and 1 GB regions use offsets that differ from the stored page number; a wrong mask either misses or returns a frame without the offset merged in.
- **Slot choice:** filling a buffer with one freed slot, and then past full, exposes a wrong victim choice as a later miss on an entry that should have stayed, or a hit on one that should be gone.
- **Same-cycle collisions:** fills, purges and lookups that collide in one cycle check R10 and R11.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int SLOT_W_MAX = 8;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_1G  = 2'd2,
    PG_RSV = 2'd3
  } pageSize_e;

  typedef struct packed {
    logic                  doFill;
    logic                  doPurge;
    logic                  doFlush;
    logic [SLOT_W_MAX-1:0] fillSlot;
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               insValid,
  input  logic               purgeValid,
  input  logic               flushAll,
  input  logic [ENTRIES-1:0] validVec,
  output tlbStrobe_t         strb
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic             anyFree;
  logic             fullFill;

  // lowest empty slot: scan downward so the lowest index is written last
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  always_comb begin
    strb.doFlush  = flushAll;
    strb.doPurge  = purgeValid;
    strb.doFill   = insValid && !purgeValid && !flushAll;
    strb.fillSlot = SLOT_W_MAX'(anyFree ? freeIdx : rrPtr);
  end

  assign fullFill = strb.doFill && !anyFree;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (fullFill) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.doFill) && $past(&validVec) |->
      rrPtr == (($past(rrPtr) == LAST_IDX) ? '0 : $past(rrPtr) + 1'b1)); // R7

  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(!(&validVec)) |-> $stable(rrPtr)); // R6

  AST_FILL_FREE: assert property (@(posedge clk) disable iff (!rstN)
    strb.doFill && !(&validVec) |-> !validVec[strb.fillSlot[IDX_W-1:0]]); // R6

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES     = 8,
  parameter int VPN_W       = 36,
  parameter int PFN_W       = 28,
  parameter int PID_W       = 8,
  parameter int SP_MID_BITS = 9,
  parameter int SP_BIG_BITS = 18
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobe_t         strb,
  input  logic               lkValid,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [PID_W-1:0]   lkPid,
  input  logic               lkWrite,
  input  logic [VPN_W-1:0]   insVpn,
  input  logic [PID_W-1:0]   insPid,
  input  logic [PFN_W-1:0]   insPfn,
  input  logic               insWritable,
  input  logic [1:0]         insSize,
  input  logic [VPN_W-1:0]   purgeVpn,
  input  logic [PID_W-1:0]   purgePid,
  output logic [ENTRIES-1:0] validVec,
  output logic               resValid,
  output logic               resHit,
  output logic               resMiss,
  output logic               resFault,
  output logic [PFN_W-1:0]   resPfn
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [VPN_W-1:0] sizeMask(input logic [1:0] sz);
    logic [VPN_W-1:0] m;
    case (pageSize_e'(sz))
      PG_2M:   m = {{(VPN_W-SP_MID_BITS){1'b0}}, {SP_MID_BITS{1'b1}}};
      PG_1G:   m = {{(VPN_W-SP_BIG_BITS){1'b0}}, {SP_BIG_BITS{1'b1}}};
      default: m = '0;
    endcase
    return m;
  endfunction

  logic [PFN_W-1:0] entPfn  [ENTRIES];
  logic [VPN_W-1:0] entMask [ENTRIES];
  logic [ENTRIES-1:0] entWr;
  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] purgeMatch;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic             vReg;
    logic [PID_W-1:0] pidReg;
    logic [VPN_W-1:0] vpnReg;
    logic [PFN_W-1:0] pfnReg;
    logic             wrReg;
    logic [1:0]       szReg;
    logic [VPN_W-1:0] maskI;
    logic             fillHere;

    assign maskI    = sizeMask(szReg);
    assign fillHere = strb.doFill && (strb.fillSlot == SLOT_W_MAX'(i));

    assign lkMatch[i]    = vReg && (pidReg == lkPid)
                           && (((lkVpn ^ vpnReg) & ~maskI) == '0);
    assign purgeMatch[i] = vReg && (pidReg == purgePid)
                           && (((purgeVpn ^ vpnReg) & ~maskI) == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vReg   <= 1'b0;
        pidReg <= '0;
        vpnReg <= '0;
        pfnReg <= '0;
        wrReg  <= 1'b0;
        szReg  <= '0;
      end else if (strb.doFlush) begin
        vReg <= 1'b0;
      end else if (strb.doPurge) begin
        if (purgeMatch[i]) vReg <= 1'b0;
      end else if (fillHere) begin
        vReg   <= 1'b1;
        pidReg <= insPid;
        vpnReg <= insVpn;
        pfnReg <= insPfn;
        wrReg  <= insWritable;
        szReg  <= insSize;
      end
    end

    assign validVec[i] = vReg;
    assign entPfn[i]   = pfnReg;
    assign entMask[i]  = maskI;
    assign entWr[i]    = wrReg;

    AST_PURGE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      $past(strb.doPurge) && $past(purgeMatch[i]) |-> !vReg); // R8
  end

  // pick the lowest matching slot
  logic [IDX_W-1:0] hitIdx;
  logic             anyMatch;
  always_comb begin
    hitIdx   = '0;
    anyMatch = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i]) begin
        hitIdx   = IDX_W'(i);
        anyMatch = 1'b1;
      end
    end
  end

  logic             permOk;
  logic [PFN_W-1:0] pMask;
  logic [PFN_W-1:0] mergedPfn;
  assign permOk    = !lkWrite || entWr[hitIdx];
  assign pMask     = entMask[hitIdx][PFN_W-1:0];
  assign mergedPfn = (entPfn[hitIdx] & ~pMask) | (lkVpn[PFN_W-1:0] & pMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resHit   <= 1'b0;
      resMiss  <= 1'b0;
      resFault <= 1'b0;
      resPfn   <= '0;
    end else begin
      resValid <= lkValid;
      resHit   <= lkValid && anyMatch && permOk;
      resMiss  <= lkValid && !anyMatch;
      resFault <= lkValid && anyMatch && !permOk;
      resPfn   <= (lkValid && anyMatch && permOk) ? mergedPfn : '0;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $countones({resHit, resMiss, resFault}) == 1); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> !resHit && !resMiss && !resFault && resPfn == '0); // R2

  AST_FAULT_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    resFault |-> $past(lkWrite)); // R4

  AST_NO_FRAME_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (resMiss || resFault) |-> resPfn == '0); // R3

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.doFlush) |-> validVec == '0); // R9

endmodule

// File: rtl/tlb_pid_cam.sv
module tlb_pid_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES     = 8,
  parameter int VPN_W       = 36,
  parameter int PFN_W       = 28,
  parameter int PID_W       = 8,
  parameter int SP_MID_BITS = 9,
  parameter int SP_BIG_BITS = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [VPN_W-1:0] lkVpn,
  input  logic [PID_W-1:0] lkPid,
  input  logic             lkWrite,
  output logic             resValid,
  output logic             resHit,
  output logic             resMiss,
  output logic             resFault,
  output logic [PFN_W-1:0] resPfn,
  input  logic             insValid,
  input  logic [VPN_W-1:0] insVpn,
  input  logic [PID_W-1:0] insPid,
  input  logic [PFN_W-1:0] insPfn,
  input  logic             insWritable,
  input  logic [1:0]       insSize,
  input  logic             purgeValid,
  input  logic [VPN_W-1:0] purgeVpn,
  input  logic [PID_W-1:0] purgePid,
  input  logic             flushAll
);

  tlbStrobe_t         strb;
  logic [ENTRIES-1:0] validVec;

  tlb_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .insValid   (insValid),
    .purgeValid (purgeValid),
    .flushAll   (flushAll),
    .validVec   (validVec),
    .strb       (strb)
  );

  tlb_datapath #(
    .ENTRIES     (ENTRIES),
    .VPN_W       (VPN_W),
    .PFN_W       (PFN_W),
    .PID_W       (PID_W),
    .SP_MID_BITS (SP_MID_BITS),
    .SP_BIG_BITS (SP_BIG_BITS)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .lkValid     (lkValid),
    .lkVpn       (lkVpn),
    .lkPid       (lkPid),
    .lkWrite     (lkWrite),
    .insVpn      (insVpn),
    .insPid      (insPid),
    .insPfn      (insPfn),
    .insWritable (insWritable),
    .insSize     (insSize),
    .purgeVpn    (purgeVpn),
    .purgePid    (purgePid),
    .validVec    (validVec),
    .resValid    (resValid),
    .resHit      (resHit),
    .resMiss     (resMiss),
    .resFault    (resFault),
    .resPfn      (resPfn)
  );

endmodule

// File: tb/tlb_pid_cam_tb.sv
`timescale 1ns/1ps
module tlb_pid_cam_tb_top;

  localparam int N   = 8;
  localparam int VW  = 36;
  localparam int PW  = 28;
  localparam int IW  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 0, lkWrite = 0;
  logic [VW-1:0] lkVpn = '0;
  logic [IW-1:0] lkPid = '0;
  logic resValid, resHit, resMiss, resFault;
  logic [PW-1:0] resPfn;
  logic insValid = 0, insWritable = 0;
  logic [VW-1:0] insVpn = '0;
  logic [IW-1:0] insPid = '0;
  logic [PW-1:0] insPfn = '0;
  logic [1:0] insSize = '0;
  logic purgeValid = 0, flushAll = 0;
  logic [VW-1:0] purgeVpn = '0;
  logic [IW-1:0] purgePid = '0;

  always #2.5 clk = ~clk;

  tlb_pid_cam dut_i (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkVpn(lkVpn), .lkPid(lkPid), .lkWrite(lkWrite),
    .resValid(resValid), .resHit(resHit), .resMiss(resMiss),
    .resFault(resFault), .resPfn(resPfn),
    .insValid(insValid), .insVpn(insVpn), .insPid(insPid), .insPfn(insPfn),
    .insWritable(insWritable), .insSize(insSize),
    .purgeValid(purgeValid), .purgeVpn(purgeVpn), .purgePid(purgePid),
    .flushAll(flushAll)
  );

  // reference model
  bit          mV  [N];
  logic [IW-1:0] mPid [N];
  logic [VW-1:0] mVpn [N];
  logic [PW-1:0] mPfn [N];
  bit          mWr [N];
  logic [1:0]  mSz [N];
  int          mRr;
  int          nChecks = 0;
  int          nFails  = 0;

  function automatic logic [VW-1:0] maskOf(input logic [1:0] s);
    if (s == 2'd1) return VW'((64'd1 << 9) - 1);
    if (s == 2'd2) return VW'((64'd1 << 18) - 1);
    return '0;
  endfunction

  function automatic bit covers(input int i, input logic [VW-1:0] v, input logic [IW-1:0] p);
    return mV[i] && (mPid[i] == p) && (((v ^ mVpn[i]) & ~maskOf(mSz[i])) == '0);
  endfunction

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin
      mV[i] = 0; mPid[i] = '0; mVpn[i] = '0; mPfn[i] = '0; mWr[i] = 0; mSz[i] = '0;
    end
    mRr = 0;
  endtask

  task automatic modelUpdate();
    if (flushAll) begin
      for (int i = 0; i < N; i++) mV[i] = 0;
    end else if (purgeValid) begin
      for (int i = 0; i < N; i++) if (covers(i, purgeVpn, purgePid)) mV[i] = 0;
    end else if (insValid) begin
      int slot = -1;
      for (int i = N - 1; i >= 0; i--) if (!mV[i]) slot = i;
      if (slot < 0) begin
        slot = mRr;
        mRr = (mRr + 1) % N;
      end
      mV[slot] = 1; mPid[slot] = insPid; mVpn[slot] = insVpn;
      mPfn[slot] = insPfn; mWr[slot] = insWritable; mSz[slot] = insSize;
    end
  endtask

  task automatic clearIn();
    lkValid = 0; lkWrite = 0; insValid = 0; purgeValid = 0; flushAll = 0;
  endtask

  // one cycle: inputs already driven after a negedge
  task automatic step(input string tag);
    logic eV, eH, eM, eF;
    logic [PW-1:0] eP;
    logic [PW-1:0] pm;
    int hit = -1;
    eV = lkValid; eH = 0; eM = 0; eF = 0; eP = '0;
    if (lkValid) begin
      for (int i = N - 1; i >= 0; i--) if (covers(i, lkVpn, lkPid)) hit = i;
      if (hit < 0) eM = 1;
      else if (lkWrite && !mWr[hit]) eF = 1;
      else begin
        eH = 1;
        pm = maskOf(mSz[hit])[PW-1:0];
        eP = (mPfn[hit] & ~pm) | (lkVpn[PW-1:0] & pm);
      end
    end
    @(posedge clk); #1;
    nChecks++;
    if ({resValid, resHit, resMiss, resFault} !== {eV, eH, eM, eF} || resPfn !== eP) begin
      nFails++;
      $display("FAIL %s: got v%0b h%0b m%0b f%0b pfn=%h, expected v%0b h%0b m%0b f%0b pfn=%h",
               tag, resValid, resHit, resMiss, resFault, resPfn, eV, eH, eM, eF, eP);
    end
    modelUpdate();
    @(negedge clk);
    clearIn();
  endtask

  task automatic setLk(input logic [VW-1:0] v, input logic [IW-1:0] p, input logic w);
    lkValid = 1; lkVpn = v; lkPid = p; lkWrite = w;
  endtask

  task automatic setIns(input logic [VW-1:0] v, input logic [IW-1:0] p,
                        input logic [PW-1:0] f, input logic w, input logic [1:0] s);
    insValid = 1; insVpn = v; insPid = p; insPfn = f; insWritable = w; insSize = s;
  endtask

  task automatic setPurge(input logic [VW-1:0] v, input logic [IW-1:0] p);
    purgeValid = 1; purgeVpn = v; purgePid = p;
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1: reset state and first lookup
    step("R1");
    setLk(36'h12345, 8'd1, 0); step("R1");

    // R3/R4: basic 4K read-only entry, pid 1
    setIns(36'h00a01, 8'd1, 28'h0abc1, 0, 2'd0); step("R6");
    setLk(36'h00a01, 8'd1, 0); step("R3");
    setLk(36'h00a01, 8'd2, 0); step("R3");
    setLk(36'h00a02, 8'd1, 0); step("R3");
    setLk(36'h00a01, 8'd1, 1); step("R4");
    step("R2");
    // writable entry
    setIns(36'h00b00, 8'd2, 28'h0777, 1, 2'd0); step("R6");
    setLk(36'h00b00, 8'd2, 1); step("R4");

    // R5: 2M and 1G regions, and reserved code
    setIns(36'h4_0000, 8'd3, 28'hfff_f000, 1, 2'd1); step("R5");
    setLk(36'h4_01ab, 8'd3, 0); step("R5");
    setLk(36'h4_0200, 8'd3, 0); step("R5");
    setIns(36'h8_0000, 8'd3, 28'hccc_0000, 0, 2'd2); step("R5");
    setLk(36'hb_ffff, 8'd3, 0); step("R5");
    setLk(36'hc_0000, 8'd3, 0); step("R5");
    setIns(36'h1_0000, 8'd4, 28'h0123456, 1, 2'd3); step("R5");
    setLk(36'h1_0001, 8'd4, 0); step("R5");

    // R11: lookup during fill sees old contents
    setIns(36'h5555, 8'd5, 28'h5555, 1, 2'd0); setLk(36'h5555, 8'd5, 0); step("R11");
    setLk(36'h5555, 8'd5, 0); step("R11");

    // R10: fill with purge in same cycle is dropped
    setIns(36'h6666, 8'd6, 28'h6666, 1, 2'd0); setPurge(36'h5555, 8'd5); step("R10");
    setLk(36'h6666, 8'd6, 0); step("R10");
    setLk(36'h5555, 8'd5, 0); step("R8");

    // R9: flush
    flushAll = 1; setIns(36'h7777, 8'd7, 28'h7777, 1, 2'd0);
    setLk(36'h00a01, 8'd1, 0); step("R11");
    setLk(36'h00a01, 8'd1, 0); step("R9");
    setLk(36'h7777, 8'd7, 0); step("R10");

    // R6/R7: fill to full, free one, overfill
    for (int k = 0; k < N; k++) begin
      setIns(36'h100 + VW'(k), 8'd9, 28'h200 + PW'(k), 1, 2'd0); step("R6");
    end
    for (int k = 0; k < N; k++) begin
      setLk(36'h100 + VW'(k), 8'd9, 0); step("R6");
    end
    setPurge(36'h103, 8'd8); step("R8");
    setLk(36'h103, 8'd9, 0); step("R8");
    setPurge(36'h103, 8'd9); step("R8");
    setIns(36'h300, 8'd9, 28'h300, 1, 2'd0); step("R6");
    setLk(36'h100, 8'd9, 0); step("R6");
    setLk(36'h300, 8'd9, 0); step("R6");
    setIns(36'h301, 8'd9, 28'h301, 1, 2'd0); step("R7");
    setLk(36'h100, 8'd9, 0); step("R7");
    setIns(36'h302, 8'd9, 28'h302, 1, 2'd0); step("R7");
    setLk(36'h101, 8'd9, 0); step("R7");
    setLk(36'h102, 8'd9, 0); step("R7");

    // random phase
    void'($urandom(32'd2024));
    for (int k = 0; k < 4000; k++) begin
      int r = int'($urandom_range(0, 99));
      logic [VW-1:0] v;
      v = VW'(($urandom % 4) << 18) | VW'(($urandom % 4) << 9) | VW'($urandom % 6);
      if (r < 70) setLk(v, IW'($urandom % 3), logic'($urandom % 2));
      r = int'($urandom_range(0, 99));
      if (r < 25) setIns(v ^ VW'($urandom % 3), IW'($urandom % 3), PW'($urandom),
                         logic'($urandom % 2), 2'($urandom % 4));
      r = int'($urandom_range(0, 99));
      if (r < 6) setPurge(v, IW'($urandom % 3));
      if (r == 99) flushAll = 1;
      step("RAND");
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule